// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block watches the command pins of a four-bank double-data-rate SDRAM. On every rising clock it samples the chip select, the row and column strobes, the write enable, the bank address, the 13-bit address and the byte write mask. It turns each pin pattern into a command and checks that command against the state of the banks. It keeps a state and an open-row register for every bank. It runs the mode-load gap, row-active minimum and precharge-recovery timers, and it starts an auto precharge at the right cycle.

Every output is registered, so the result of a command sampled at clock edge k is visible after edge k. A command that breaks a rule is refused: the illegal flag rises for that one cycle and no state changes. The decoded-command output reports only accepted commands.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: With `cs_n` high no command is taken, whatever the other pins carry. `cmd_o` reads NOP and the bank states hold. Timers and an auto precharge already under way still advance.
- R2: With `cs_n` low, the levels `{ras_n,cas_n,we_n}` decode as follows: 011 activate, 101 read, 100 write, 010 precharge, 000 mode load, and every other pattern NOP. The `cmd_o` codes are 0 NOP, 1 activate, 2 read, 3 write, 4 precharge and 5 mode load. Bank b's state sits at `bank_state_o[2b+1:2b]`, with 0 idle, 1 active and 2 precharging. After reset all banks are idle and `cmd_o`, `illegal_o` and `wr_en_o` are zero.
- R3: A mode load is accepted only while every bank is idle, and it copies `addr` into `mode_o`. Any non-NOP command in the T_MRD-1 cycles that follow is illegal.
- R4: Activate moves the bank chosen by `ba` from idle to active and stores `addr` in that bank's row field at `open_row_o[13b+12:13b]`. An activate to a bank that is not idle is illegal.
- R5: A read or write is accepted only to an active bank that has no auto precharge pending, and only once the previous burst's BURST_LEN/2 cycles have passed. Bursts may run back to back.
- R6: Address bit 10 on a read or write requests auto precharge for that command only. A later read or write without it leaves the bank open.
- R7: A precharge with address bit 10 high closes every active bank and ignores `ba`. With bit 10 low it closes only the bank chosen by `ba`.
- R8: A precharge whose targets are all idle or already precharging reports NOP, does not raise `illegal_o`, and leaves the state and timers unchanged.
- R9: A bank that enters precharge at edge p reads precharging until edge p+T_RP and reads idle from then on.
- R10: For an auto precharge, a read or write at edge a+d, where the bank was activated at edge a, puts the bank into precharge at edge a+max(d+BURST_LEN/2, T_RAS).
- R11: While one bank waits for its auto precharge, a read or write to another bank is accepted once the bus is free, even in the cycle the precharge starts.
- R12: For the BURST_LEN/2 edges after an accepted write, `wr_en_o` registers the inverse of `dm`, so mask bit 1 blocks its byte. Outside that window `wr_en_o` is zero.
- R13: An explicit precharge to an active bank fewer than T_RAS cycles after its activate is illegal. An illegal command reports NOP, raises `illegal_o` for one cycle and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| addr | input | 13 | Row, column or mode value; bit 10 selects auto or all-bank precharge |
| dm | input | 2 | Byte write mask, high blocks the byte |
| cmd_o | output | 3 | Accepted command code |
| illegal_o | output | 1 | Refused command in the previous cycle |
| bank_state_o | output | 8 | Two state bits per bank |
| open_row_o | output | 52 | Row field of each bank, 13 bits per bank |
| mode_o | output | 13 | Last value loaded by a mode load |
| wr_en_o | output | 2 | Per-byte write enable for the current beat |

## Verification
Two things can land on the same clock edge: a bank's auto precharge starting on its own, and a new read or write to a different bank. The bench sets this up on purpose. It issues an auto-precharge read to one bank, then places a read to a second bank on exactly the edge where the first burst ends. After that edge, the first bank must read precharging while `cmd_o` reports the second read with no illegal flag. A sweep over the delay from activate to read also moves the precharge start between the burst end and the T_RAS limit, and each sweep step is compared cycle by cycle against the maximum computed in the bench.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_LMR = 3'd5
    } cmd_e;

    typedef enum logic [1:0] {
        BK_IDLE = 2'd0,
        BK_ACT  = 2'd1,
        BK_PRE  = 2'd2
    } bank_st_e;

    typedef struct packed {
        logic act;
        logic rw;
        logic ap;
        logic pre;
    } bank_req_t;

    localparam int FLAG_BIT = 10;

    function automatic cmd_e decode_pins(input logic cs_n, input logic ras_n,
                                         input logic cas_n, input logic we_n);
        cmd_e c;
        case ({ras_n, cas_n, we_n})
            3'b011:  c = CMD_ACT;
            3'b101:  c = CMD_RD;
            3'b100:  c = CMD_WR;
            3'b010:  c = CMD_PRE;
            3'b000:  c = CMD_LMR;
            default: c = CMD_NOP;
        endcase
        return cs_n ? CMD_NOP : c;
    endfunction

endpackage

// File: rtl/sdram_bank_fsm.sv
module sdram_bank_fsm
    import sdram_cmd_pkg::*;
#(
    parameter int ROW_W     = 13,
    parameter int T_RAS     = 5,
    parameter int T_RP      = 3,
    parameter int BURST_CYC = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  bank_req_t        req,
    input  logic [ROW_W-1:0] row_in,
    output bank_st_e         st_o,
    output logic [ROW_W-1:0] row_o,
    output logic             ras_done_o,
    output logic             ap_pend_o
);
    localparam int RAS_W = $clog2(T_RAS + 1);
    localparam int RP_W  = $clog2(T_RP + 1);
    localparam int BC_W  = $clog2(BURST_CYC + 1);

    bank_st_e         st;
    logic [ROW_W-1:0] row;
    logic [RAS_W-1:0] ras_cnt;
    logic [RP_W-1:0]  rp_cnt;
    logic [BC_W-1:0]  bc_cnt;
    logic             ap;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= BK_IDLE;
            row     <= '0;
            ras_cnt <= '0;
            rp_cnt  <= '0;
            bc_cnt  <= '0;
            ap      <= 1'b0;
        end else begin
            if (ras_cnt != 0) ras_cnt <= ras_cnt - 1'b1;
            if (bc_cnt != 0)  bc_cnt  <= bc_cnt - 1'b1;
            unique case (st)
                BK_IDLE: if (req.act) begin
                    st      <= BK_ACT;
                    row     <= row_in;
                    ras_cnt <= RAS_W'(T_RAS - 1);
                    ap      <= 1'b0;
                end
                BK_ACT: begin
                    if (req.pre || (ap && bc_cnt == 0 && ras_cnt == 0)) begin
                        st     <= BK_PRE;
                        rp_cnt <= RP_W'(T_RP - 1);
                        ap     <= 1'b0;
                    end else if (req.rw) begin
                        bc_cnt <= BC_W'(BURST_CYC - 1);
                        ap     <= req.ap;
                    end
                end
                BK_PRE: begin
                    if (rp_cnt == 0) st <= BK_IDLE;
                    else             rp_cnt <= rp_cnt - 1'b1;
                end
                default: st <= BK_IDLE;
            endcase
        end
    end

    assign st_o       = st;
    assign row_o      = row;
    assign ras_done_o = (ras_cnt == 0);
    assign ap_pend_o  = ap;

    // R4
    act_from_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (st == BK_ACT && $past(st) != BK_ACT) |-> $past(st) == BK_IDLE);
    // R4
    row_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st == BK_ACT && $past(st) == BK_ACT) |-> $stable(row));
    // R10
    ap_ras_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(st) == BK_ACT && st == BK_PRE && !$past(req.pre)) |-> $past(ras_done_o));
    // R6
    ap_only_open_chk: assert property (@(posedge clk) disable iff (rst)
        ap |-> st == BK_ACT);

endmodule

// File: rtl/sdram_burst_track.sv
module sdram_burst_track #(
    parameter int BURST_CYC = 2,
    parameter int MASK_W    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rw_go,
    input  logic              wr_go,
    input  logic [MASK_W-1:0] dm,
    output logic              bus_free_o,
    output logic [MASK_W-1:0] wr_en_o
);
    localparam int BW = $clog2(BURST_CYC + 1);

    logic [BW-1:0]     bus_cnt;
    logic [BW-1:0]     wr_left;
    logic [MASK_W-1:0] wr_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_cnt <= '0;
            wr_left <= '0;
            wr_en   <= '0;
        end else begin
            if (rw_go)              bus_cnt <= BW'(BURST_CYC - 1);
            else if (bus_cnt != 0)  bus_cnt <= bus_cnt - 1'b1;
            wr_en <= (wr_left != 0) ? ~dm : '0;
            if (wr_go)              wr_left <= BW'(BURST_CYC);
            else if (wr_left != 0)  wr_left <= wr_left - 1'b1;
        end
    end

    assign bus_free_o = (bus_cnt == 0);
    assign wr_en_o    = wr_en;

    // R12
    wr_window_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en != 0) |-> $past(wr_left) != 0);
    // R5
    bus_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        rw_go |-> bus_cnt == 0);

endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
    import sdram_cmd_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 13,
    parameter int MASK_W    = 2,
    parameter int BURST_LEN = 4,
    parameter int T_MRD     = 2,
    parameter int T_RP      = 3,
    parameter int T_RAS     = 5
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cs_n,
    input  logic                       ras_n,
    input  logic                       cas_n,
    input  logic                       we_n,
    input  logic [$clog2(NUM_BANKS)-1:0] ba,
    input  logic [ROW_W-1:0]           addr,
    input  logic [MASK_W-1:0]          dm,
    output logic [2:0]                 cmd_o,
    output logic                       illegal_o,
    output logic [2*NUM_BANKS-1:0]     bank_state_o,
    output logic [ROW_W*NUM_BANKS-1:0] open_row_o,
    output logic [ROW_W-1:0]           mode_o,
    output logic [MASK_W-1:0]          wr_en_o
);
    localparam int BA_W      = $clog2(NUM_BANKS);
    localparam int BURST_CYC = BURST_LEN / 2;
    localparam int MRD_W     = $clog2(T_MRD + 1);

    cmd_e             pin_cmd;
    cmd_e             cmd_q;
    bank_st_e         st [NUM_BANKS];
    logic [ROW_W-1:0] rows [NUM_BANKS];
    bank_req_t        req [NUM_BANKS];
    logic [NUM_BANKS-1:0] ras_done, ap_pend;
    logic             bus_free, legal, redundant, go, all_idle, any_act, unripe;
    logic [MRD_W-1:0] mrd_cnt;
    logic [ROW_W-1:0] mode_q;
    logic             illegal_q;

    assign pin_cmd = decode_pins(cs_n, ras_n, cas_n, we_n);

    always_comb begin
        all_idle  = 1'b1;
        any_act   = 1'b0;
        unripe    = 1'b0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (st[b] != BK_IDLE) all_idle = 1'b0;
            if (st[b] == BK_ACT) begin
                any_act = 1'b1;
                if (!ras_done[b]) unripe = 1'b1;
            end
        end
        redundant = 1'b0;
        unique case (pin_cmd)
            CMD_ACT: legal = (st[ba] == BK_IDLE);
            CMD_RD, CMD_WR:
                legal = (st[ba] == BK_ACT) && !ap_pend[ba] && bus_free;
            CMD_PRE: begin
                if (addr[FLAG_BIT]) begin
                    legal     = !unripe;
                    redundant = !any_act;
                end else begin
                    legal     = (st[ba] != BK_ACT) || ras_done[ba];
                    redundant = (st[ba] != BK_ACT);
                end
            end
            CMD_LMR: legal = all_idle;
            default: legal = 1'b1;
        endcase
        if (mrd_cnt != 0 && pin_cmd != CMD_NOP) legal = 1'b0;
        go = legal && !redundant && (pin_cmd != CMD_NOP);
        for (int b = 0; b < NUM_BANKS; b++) begin
            req[b].act = go && pin_cmd == CMD_ACT && ba == BA_W'(b);
            req[b].rw  = go && (pin_cmd == CMD_RD || pin_cmd == CMD_WR) && ba == BA_W'(b);
            req[b].ap  = addr[FLAG_BIT];
            req[b].pre = go && pin_cmd == CMD_PRE &&
                         (addr[FLAG_BIT] ? (st[b] == BK_ACT) : (ba == BA_W'(b)));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q     <= CMD_NOP;
            illegal_q <= 1'b0;
            mode_q    <= '0;
            mrd_cnt   <= '0;
        end else begin
            cmd_q     <= go ? pin_cmd : CMD_NOP;
            illegal_q <= !legal;
            if (go && pin_cmd == CMD_LMR) begin
                mode_q  <= addr;
                mrd_cnt <= MRD_W'(T_MRD - 1);
            end else if (mrd_cnt != 0) begin
                mrd_cnt <= mrd_cnt - 1'b1;
            end
        end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        sdram_bank_fsm #(
            .ROW_W(ROW_W), .T_RAS(T_RAS), .T_RP(T_RP), .BURST_CYC(BURST_CYC)
        ) u_bank (
            .clk(clk), .rst(rst), .req(req[b]), .row_in(addr),
            .st_o(st[b]), .row_o(rows[b]),
            .ras_done_o(ras_done[b]), .ap_pend_o(ap_pend[b])
        );
        assign bank_state_o[2*b +: 2]         = st[b];
        assign open_row_o[ROW_W*b +: ROW_W]   = rows[b];
    end

    sdram_burst_track #(.BURST_CYC(BURST_CYC), .MASK_W(MASK_W)) u_burst (
        .clk(clk), .rst(rst),
        .rw_go(go && (pin_cmd == CMD_RD || pin_cmd == CMD_WR)),
        .wr_go(go && pin_cmd == CMD_WR),
        .dm(dm), .bus_free_o(bus_free), .wr_en_o(wr_en_o)
    );

    assign cmd_o     = cmd_q;
    assign illegal_o = illegal_q;
    assign mode_o    = mode_q;

    // R3
    lmr_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_q == CMD_LMR) |-> $past(all_idle));
    // R3
    mrd_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (T_MRD > 1 && $past(cmd_q) == CMD_LMR) |-> cmd_q == CMD_NOP);
    // R13
    illegal_nop_chk: assert property (@(posedge clk) disable iff (rst)
        illegal_q |-> cmd_q == CMD_NOP);

endmodule

// File: tb/sdram_cmd_tracker_tb.sv
`timescale 1ns/1ps
module sdram_cmd_tracker_tb;
    localparam int TMRD = 2, TRP = 3, TRAS = 5, BL = 4, BC = BL / 2;
    localparam logic [2:0] P_ACT = 3'b011, P_RD = 3'b101, P_WR = 3'b100,
                           P_PRE = 3'b010, P_LMR = 3'b000, P_NOP = 3'b111;

    logic clk = 1'b0;
    logic rst, cs_n, ras_n, cas_n, we_n;
    logic [1:0] ba, dm, wr_en_o;
    logic [12:0] addr, mode_o;
    logic [2:0] cmd_o;
    logic illegal_o;
    logic [7:0] bank_state_o;
    logic [51:0] open_row_o;
    int checks = 0, fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sdram_cmd_tracker #(.NUM_BANKS(4), .ROW_W(13), .MASK_W(2), .BURST_LEN(BL),
        .T_MRD(TMRD), .T_RP(TRP), .T_RAS(TRAS)) u_dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .addr(addr), .dm(dm), .cmd_o(cmd_o), .illegal_o(illegal_o),
        .bank_state_o(bank_state_o), .open_row_o(open_row_o), .mode_o(mode_o),
        .wr_en_o(wr_en_o));

    function automatic int st(input int b);
        return int'(bank_state_o[2*b +: 2]);
    endfunction
    function automatic int row(input int b);
        return int'(open_row_o[13*b +: 13]);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(input logic c, input logic [2:0] p, input logic [1:0] b,
                         input logic [12:0] a, input logic [1:0] m);
        cs_n = c; {ras_n, cas_n, we_n} = p; ba = b; addr = a; dm = m;
        @(negedge clk);
    endtask
    task automatic cmd(input logic [2:0] p, input logic [1:0] b, input logic [12:0] a);
        drive(1'b0, p, b, a, 2'b00);
    endtask
    task automatic nop(input int n);
        repeat (n) drive(1'b1, P_NOP, 2'd0, 13'd0, 2'b00);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run hung, actual=running expected=done");
            finish_run();
        end
    end

    initial begin
        rst = 1'b1; cs_n = 1'b1; {ras_n, cas_n, we_n} = P_NOP; ba = '0; addr = '0; dm = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R2 reset state
        chk("R2 reset cmd", cmd_o, 0);
        chk("R2 reset illegal", illegal_o, 0);
        chk("R2 reset states", bank_state_o, 0);
        chk("R2 reset wr_en", wr_en_o, 0);
        // R1 deselect hides an activate pattern
        drive(1'b1, P_ACT, 2'd0, 13'd5, 2'b00);
        chk("R1 deselect cmd", cmd_o, 0);
        chk("R1 deselect bank0", st(0), 0);
        // R2 unsupported pattern reads NOP, not illegal
        cmd(3'b001, 2'd0, 13'd0);
        chk("R2 other code cmd", cmd_o, 0);
        chk("R2 other code illegal", illegal_o, 0);
        // R3 mode load and gap
        cmd(P_LMR, 2'd0, 13'h123);
        chk("R3 lmr cmd", cmd_o, 5);
        chk("R3 lmr value", mode_o, 13'h123);
        cmd(P_ACT, 2'd0, 13'h1AB);
        chk("R3 gap illegal", illegal_o, 1);
        chk("R13 gap cmd nop", cmd_o, 0);
        chk("R13 gap bank0 idle", st(0), 0);
        cmd(P_ACT, 2'd0, 13'h1AB);
        chk("R13 flag one cycle", illegal_o, 0);
        chk("R4 act cmd", cmd_o, 1);
        chk("R4 bank0 active", st(0), 1);
        chk("R4 row0", row(0), 13'h1AB);
        cmd(P_ACT, 2'd0, 13'h055);
        chk("R4 reopen illegal", illegal_o, 1);
        chk("R4 row0 kept", row(0), 13'h1AB);
        cmd(P_LMR, 2'd0, 13'h007);
        chk("R3 lmr busy illegal", illegal_o, 1);
        chk("R3 mode kept", mode_o, 13'h123);
        cmd(P_ACT, 2'd3, 13'h0F0);
        chk("R4 row3", row(3), 13'h0F0);
        nop(TRAS);
        // R8 redundant single precharge
        cmd(P_PRE, 2'd2, 13'd0);
        chk("R8 idle pre cmd", cmd_o, 0);
        chk("R8 idle pre illegal", illegal_o, 0);
        // R5 read to idle bank
        cmd(P_RD, 2'd2, 13'd0);
        chk("R5 read idle illegal", illegal_o, 1);
        // R12 write beats, R5 bus busy
        cmd(P_WR, 2'd0, 13'h010);
        chk("R5 write cmd", cmd_o, 3);
        chk("R12 no beat yet", wr_en_o, 0);
        drive(1'b0, P_RD, 2'd0, 13'h020, 2'b01);
        chk("R5 bus busy illegal", illegal_o, 1);
        chk("R12 beat1", wr_en_o, 2'b10);
        drive(1'b0, P_RD, 2'd3, 13'h020, 2'b10);
        chk("R5 back to back read", cmd_o, 2);
        chk("R12 beat2", wr_en_o, 2'b01);
        nop(1);
        chk("R12 window closed", wr_en_o, 0);
        // R10/R11 auto precharge with concurrent read to other bank
        cmd(P_RD, 2'd0, 13'h400);
        chk("R6 ap read cmd", cmd_o, 2);
        chk("R10 bank0 still open", st(0), 1);
        cmd(P_RD, 2'd0, 13'h000);
        chk("R5 ap pending illegal", illegal_o, 1);
        cmd(P_RD, 2'd3, 13'h000);
        chk("R11 other bank read", cmd_o, 2);
        chk("R11 no flag", illegal_o, 0);
        chk("R11 bank0 precharging", st(0), 2);
        for (int j = 1; j <= TRP; j++) begin
            nop(1);
            chk("R9 recovery", st(0), (j < TRP) ? 2 : 0);
        end
        // R6 nonpersistent
        cmd(P_ACT, 2'd0, 13'h0AA);
        nop(TRAS);
        cmd(P_RD, 2'd0, 13'h001);
        nop(8);
        chk("R6 bank0 stays open", st(0), 1);
        // R7 precharge all
        cmd(P_PRE, 2'd1, 13'h400);
        chk("R7 all cmd", cmd_o, 4);
        chk("R7 bank0 closing", st(0), 2);
        chk("R7 bank3 closing", st(3), 2);
        chk("R7 bank1 idle", st(1), 0);
        cmd(P_PRE, 2'd0, 13'd0);
        chk("R8 closing pre cmd", cmd_o, 0);
        chk("R8 closing pre flag", illegal_o, 0);
        nop(TRP);
        chk("R9 bank0 idle", st(0), 0);
        chk("R9 bank3 idle", st(3), 0);
        cmd(P_ACT, 2'd2, 13'd1);
        cmd(P_PRE, 2'd0, 13'h400);
        chk("R13 all unripe illegal", illegal_o, 1);
        chk("R13 bank2 kept", st(2), 1);
        nop(TRAS);
        cmd(P_PRE, 2'd2, 13'd0);
        chk("R7 single close", st(2), 2);
        nop(TRP);
        cmd(P_PRE, 2'd0, 13'h400);
        chk("R8 all idle nop", cmd_o, 0);
        chk("R8 all idle flag", illegal_o, 0);
        // R13 sweep of explicit precharge delay
        for (int d = 1; d <= TRAS + 1; d++) begin
            cmd(P_ACT, 2'd1, 13'(d));
            nop(d - 1);
            cmd(P_PRE, 2'd1, 13'd0);
            chk("R13 tras sweep flag", illegal_o, (d < TRAS) ? 1 : 0);
            chk("R13 tras sweep state", st(1), (d < TRAS) ? 1 : 2);
            nop(TRAS);
            cmd(P_PRE, 2'd1, 13'd0);
            nop(TRP);
        end
        // R10 sweep of auto precharge start
        for (int d = 1; d <= TRAS + 1; d++) begin
            int f;
            f = (d + BC > TRAS) ? d + BC : TRAS;
            cmd(P_ACT, 2'd1, 13'd0);
            nop(d - 1);
            cmd((d % 2) ? P_WR : P_RD, 2'd1, 13'h400);
            chk("R10 ap accepted", cmd_o, (d % 2) ? 3 : 2);
            for (int t = d + 1; t <= f + TRP; t++) begin
                nop(1);
                chk("R10 ap timing", st(1), (t < f) ? 1 : ((t < f + TRP) ? 2 : 0));
            end
        end
        // R12 mask sweep
        cmd(P_ACT, 2'd2, 13'd0);
        for (int m = 0; m < 4; m++) begin
            cmd(P_WR, 2'd2, 13'd0);
            chk("R12 write cmd", cmd_o, 3);
            drive(1'b1, P_NOP, 2'd0, 13'd0, 2'(m));
            chk("R12 mask beat1", wr_en_o, 3 - m);
            drive(1'b1, P_NOP, 2'd0, 13'd0, 2'(3 - m));
            chk("R12 mask beat2", wr_en_o, m);
        end
        done = 1;
        finish_run();
    end
endmodule